// File: doc/BRIEF.md
# Per-Bit Access-Policy Control Register

A single control/status register, 32 bits wide by default, in which every bit carries its own access policy. An elaboration-time vector holds a 4-bit policy code per bit. Software reaches the register through a plain strobe port: read strobe, write strobe, byte enables, write data, and read data that reflects the current contents in the same cycle. Hardware reaches it through per-bit set, clear and update inputs, a global lock input and a per-bit event output.

Two resets are kept apart. The active-low asynchronous `rst_ni` is the power-on reset: it restores every bit and forgets all write-once history. The synchronous `hard_rst_i` restores every non-sticky bit to its default value. Sticky bits and the write-once history survive it.

Top module: `attr_reg`

## Requirements
- R1: A bit with policy code 0 (read-only) reads back `hw_val_i` of that bit in the same cycle. Software writes and hardware events never change what it reads.
- R2: A bit with code 1 (write-only event) always reads 0. A write whose byte enable covers the bit and whose data bit is 1 raises that bit of `evt_o` for exactly the next cycle. Otherwise that bit of `evt_o` is 0.
- R3: A bit with code 2 (read/write) takes the written data bit. Byte enable k covers bits 8k+7..8k, and bits of bytes whose enable is low keep their value.
- R4: A bit with code 3 or code 4 (read-clear) returns its value on a read and is 0 after that read's clock edge. A code-3 bit ignores writes. A code-4 bit accepts writes, and a write in the same cycle as a read wins.
- R5: A bit with code 5 is cleared by writing 1 to it, and a bit with code 6 is cleared by writing 0 to it. Writing the other value has no effect.
- R6: A bit with code 7 is set by writing 1 to it, and a bit with code 8 is set by writing 0 to it. Writing the other value has no effect. Only `hw_clr_i` (or `hw_upd_i` with a 0, or a reset) returns it to 0.
- R7: A bit with code 9 behaves as read/write while `lock_i` is 0. It ignores writes while `lock_i` is 1.
- R8: A bit with code 10 accepts the first write that covers it after power-on and ignores all later writes. A write that does not cover it leaves it still writable once.
- R9: The restricted field (code 11, bits RR_LSB upward for RR_W bits) takes a write only when every byte it spans is enabled and bit v of RR_ALLOWED is 1, where v is the written field value. Otherwise the whole field is unchanged.
- R10: For every bit with code 2 or above, the hardware inputs override software in the order set, then clear, then update. A hardware set and a software clear in the same cycle leave the bit at 1.
- R11: `hard_rst_i` returns every non-sticky bit to its RST_VAL default and clears `evt_o`. It leaves sticky bits and the write-once history untouched, and it overrides all other inputs in that cycle.
- R12: While `rst_ni` is low, every bit holds its default value, `evt_o` is 0 and every write-once bit becomes writable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| hard_rst_i | input | 1 | Synchronous hard reset; sticky bits keep their value |
| rd_i | input | 1 | Read strobe (drives the read-clear side effects) |
| wr_i | input | 1 | Write strobe |
| be_i | input | NB/8 | Byte enables, bit k covers data bits 8k+7..8k |
| wdata_i | input | NB | Write data |
| rdata_o | output | NB | Current register view |
| hw_set_i | input | NB | Per-bit hardware set |
| hw_clr_i | input | NB | Per-bit hardware clear |
| hw_upd_i | input | NB | Per-bit hardware load of `hw_val_i` |
| hw_val_i | input | NB | Hardware value for read-only bits and for update loads |
| lock_i | input | 1 | Freezes the lockable bits |
| evt_o | output | NB | One-cycle pulses from write-only bits |

## Verification
The hardest state to reach is a write-once field whose two bits are in different bytes and have been consumed at different times. Reaching it needs a partial-byte write, then a second write that covers only the other byte, then a full write that must be ignored. The directed prologue builds this sequence right after power-on, before any full-width write can spend both bits. It then drives a restricted-field write with one byte masked, and a hardware set that collides with a software clear. Long random traffic follows, with sparse hardware events, lock toggles, hard resets and one power-on reset in the middle. The reference model is compared on every cycle throughout.

// File: rtl/attr_reg_pkg.sv
package attr_reg_pkg;
  typedef enum logic [3:0] {
    ATTR_RO  = 4'd0,
    ATTR_WO  = 4'd1,
    ATTR_RW  = 4'd2,
    ATTR_RC  = 4'd3,
    ATTR_RCW = 4'd4,
    ATTR_W1C = 4'd5,
    ATTR_W0C = 4'd6,
    ATTR_W1S = 4'd7,
    ATTR_W0S = 4'd8,
    ATTR_RWL = 4'd9,
    ATTR_RWO = 4'd10,
    ATTR_RRW = 4'd11
  } attr_e;

  function automatic logic has_store(attr_e a);
    return (a != ATTR_RO) && (a != ATTR_WO);
  endfunction
endpackage

// File: rtl/attr_reg_rrw.sv
module attr_reg_rrw #(
  parameter int NBYTE = 4,
  parameter int RR_LSB = 22,
  parameter int RR_W = 4,
  parameter logic [2**RR_W-1:0] ALLOWED = '1
) (
  input  logic [NBYTE-1:0] be_i,
  input  logic [RR_W-1:0]  val_i,
  output logic             ok_o
);
  localparam int FB = RR_LSB / 8;
  localparam int LB = (RR_LSB + RR_W - 1) / 8;

  logic [NBYTE-1:0] need;
  for (genvar k = 0; k < NBYTE; k++) begin : g_need
    assign need[k] = (k >= FB) && (k <= LB);
  end

  // every spanned byte enabled and value in the allowed set
  assign ok_o = (&(be_i | ~need)) && ALLOWED[val_i];
endmodule

// File: rtl/attr_reg_bit.sv
module attr_reg_bit
  import attr_reg_pkg::*;
#(
  parameter attr_e ATTR   = ATTR_RW,
  parameter bit    RST    = 1'b0,
  parameter bit    STICKY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic wr_en_i,
  input  logic wd_i,
  input  logic rd_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic upd_i,
  input  logic hv_i,
  input  logic lock_i,
  input  logic rrw_ok_i,
  output logic rbit_o,
  output logic evt_o
);
  logic q, done_q, evt_q;
  logic sw_nxt, nxt, done_nxt;

  always_comb begin
    sw_nxt = q;
    case (ATTR)
      ATTR_RW:  if (wr_en_i) sw_nxt = wd_i;
      ATTR_RC:  if (rd_i) sw_nxt = 1'b0;
      ATTR_RCW: begin
        if (rd_i) sw_nxt = 1'b0;
        if (wr_en_i) sw_nxt = wd_i;
      end
      ATTR_W1C: if (wr_en_i && wd_i) sw_nxt = 1'b0;
      ATTR_W0C: if (wr_en_i && !wd_i) sw_nxt = 1'b0;
      ATTR_W1S: if (wr_en_i && wd_i) sw_nxt = 1'b1;
      ATTR_W0S: if (wr_en_i && !wd_i) sw_nxt = 1'b1;
      ATTR_RWL: if (wr_en_i && !lock_i) sw_nxt = wd_i;
      ATTR_RWO: if (wr_en_i && !done_q) sw_nxt = wd_i;
      ATTR_RRW: if (wr_en_i && rrw_ok_i) sw_nxt = wd_i;
      default: ;
    endcase
    // hardware wins: set > clr > upd > software
    if (set_i)      nxt = 1'b1;
    else if (clr_i) nxt = 1'b0;
    else if (upd_i) nxt = hv_i;
    else            nxt = sw_nxt;
    done_nxt = done_q | ((ATTR == ATTR_RWO) && wr_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= RST;
      done_q <= 1'b0;
      evt_q  <= 1'b0;
    end else if (hard_rst_i) begin
      evt_q <= 1'b0;
      if (!STICKY) q <= RST;
    end else begin
      q      <= nxt;
      done_q <= done_nxt;
      evt_q  <= (ATTR == ATTR_WO) && wr_en_i && wd_i;
    end
  end

  assign rbit_o = (ATTR == ATTR_RO) ? hv_i :
                  (ATTR == ATTR_WO) ? 1'b0 : q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/attr_reg.sv
module attr_reg
  import attr_reg_pkg::*;
#(
  parameter int NB = 32,
  parameter logic [NB*4-1:0] ATTR = 128'h2222_55BB_BB22_229A_A987_6543_2211_0000,
  parameter logic [NB-1:0] RST_VAL = 32'h1041_0040,
  parameter logic [NB-1:0] STICKY  = 32'h0C0C_0000,
  parameter int RR_LSB = 22,
  parameter int RR_W   = 4,
  parameter logic [2**RR_W-1:0] RR_ALLOWED = 16'h042A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hard_rst_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [NB/8-1:0]    be_i,
  input  logic [NB-1:0]      wdata_i,
  output logic [NB-1:0]      rdata_o,
  input  logic [NB-1:0]      hw_set_i,
  input  logic [NB-1:0]      hw_clr_i,
  input  logic [NB-1:0]      hw_upd_i,
  input  logic [NB-1:0]      hw_val_i,
  input  logic               lock_i,
  output logic [NB-1:0]      evt_o
);
  localparam int NBYTE = NB / 8;

  logic rrw_ok;

  attr_reg_rrw #(
    .NBYTE(NBYTE), .RR_LSB(RR_LSB), .RR_W(RR_W), .ALLOWED(RR_ALLOWED)
  ) u_rrw (
    .be_i (be_i),
    .val_i(wdata_i[RR_LSB +: RR_W]),
    .ok_o (rrw_ok)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bit
    attr_reg_bit #(
      .ATTR  (attr_e'(ATTR[4*b +: 4])),
      .RST   (RST_VAL[b]),
      .STICKY(STICKY[b])
    ) u_bit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hard_rst_i(hard_rst_i),
      .wr_en_i   (wr_i && be_i[b/8]),
      .wd_i      (wdata_i[b]),
      .rd_i      (rd_i),
      .set_i     (hw_set_i[b]),
      .clr_i     (hw_clr_i[b]),
      .upd_i     (hw_upd_i[b]),
      .hv_i      (hw_val_i[b]),
      .lock_i    (lock_i),
      .rrw_ok_i  (rrw_ok),
      .rbit_o    (rdata_o[b]),
      .evt_o     (evt_o[b])
    );
  end
endmodule

module attr_reg_chk
  import attr_reg_pkg::*;
#(
  parameter int NB = 32,
  parameter logic [NB*4-1:0] ATTR = '0,
  parameter logic [NB-1:0] RST_VAL = '0,
  parameter logic [NB-1:0] STICKY  = '0,
  parameter int RR_LSB = 22,
  parameter int RR_W   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            hard_rst_i,
  input logic            rd_i,
  input logic            wr_i,
  input logic [NB/8-1:0] be_i,
  input logic [NB-1:0]   wdata_i,
  input logic [NB-1:0]   rdata_o,
  input logic [NB-1:0]   hw_set_i,
  input logic [NB-1:0]   hw_clr_i,
  input logic [NB-1:0]   hw_upd_i,
  input logic [NB-1:0]   hw_val_i,
  input logic            lock_i,
  input logic [NB-1:0]   evt_o
);
  localparam int FB = RR_LSB / 8;
  localparam int LB = (RR_LSB + RR_W - 1) / 8;

  logic unused_sink;
  assign unused_sink = ^{wdata_i, hw_val_i, hw_upd_i, hw_clr_i, hw_set_i,
                         be_i, evt_o, rdata_o, rd_i, wr_i, lock_i};

  for (genvar b = 0; b < NB; b++) begin : g_b
    localparam attr_e A = attr_e'(ATTR[4*b +: 4]);
    if (A == ATTR_RO) begin : g_ro
      assert_ro_follows_hw_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[b] == hw_val_i[b]);
    end else if (A == ATTR_WO) begin : g_wo
      assert_wo_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && be_i[b/8] && wdata_i[b] && !hard_rst_i) |=> evt_o[b]);
      assert_wo_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> !evt_o[b]);
      assert_wo_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rdata_o[b]);
    end else begin : g_st
      assert_hw_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_set_i[b] && !hard_rst_i) |=> rdata_o[b]);
      if (STICKY[b]) begin : g_stk
        assert_sticky_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
          hard_rst_i |=> $stable(rdata_o[b]));
      end else begin : g_nstk
        assert_hard_default_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
          hard_rst_i |=> (rdata_o[b] == RST_VAL[b]));
      end
      if (A == ATTR_RC) begin : g_rc
        assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (rd_i && !hard_rst_i && !hw_set_i[b] && !hw_upd_i[b]) |=> !rdata_o[b]);
      end
      if (A == ATTR_W1S || A == ATTR_W0S) begin : g_set
        assert_set_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (rdata_o[b] && !hw_clr_i[b] && !hw_upd_i[b] && !hard_rst_i) |=> rdata_o[b]);
      end
      if (A == ATTR_RWL) begin : g_rwl
        assert_locked_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (lock_i && !hard_rst_i && !hw_set_i[b] && !hw_clr_i[b] && !hw_upd_i[b])
          |=> $stable(rdata_o[b]));
      end
    end
  end

  assert_rrw_partial_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !(&be_i[LB:FB]) && !hard_rst_i &&
     !(|hw_set_i[RR_LSB +: RR_W]) && !(|hw_clr_i[RR_LSB +: RR_W]) &&
     !(|hw_upd_i[RR_LSB +: RR_W]))
    |=> $stable(rdata_o[RR_LSB +: RR_W]));
endmodule

bind attr_reg attr_reg_chk #(
  .NB(NB), .ATTR(ATTR), .RST_VAL(RST_VAL), .STICKY(STICKY),
  .RR_LSB(RR_LSB), .RR_W(RR_W)
) u_chk (.*);

// File: tb/attr_reg_bench.sv
module attr_reg_bench;
  localparam int CLK_P = 10;
  localparam int NB = 32;
  localparam logic [NB*4-1:0] B_ATTR = 128'h2222_55BB_BB22_229A_A987_6543_2211_0000;
  localparam logic [NB-1:0] B_RST = 32'h1041_0040;
  localparam logic [NB-1:0] B_STK = 32'h0C0C_0000;
  localparam logic [15:0] B_ALW = 16'h042A;

  logic clk_i = 0, rst_ni = 0, hard_rst_i = 0, rd_i = 0, wr_i = 0, lock_i = 0;
  logic [3:0] be_i = '0;
  logic [NB-1:0] wdata_i = '0, hw_set_i = '0, hw_clr_i = '0, hw_upd_i = '0, hw_val_i = '0;
  logic [NB-1:0] rdata_o, evt_o;

  int n_chk = 0, n_fail = 0;
  bit [NB-1:0] m_q, m_done, m_evt;

  always #(CLK_P/2) clk_i = ~clk_i;

  attr_reg #(.NB(NB), .ATTR(B_ATTR), .RST_VAL(B_RST), .STICKY(B_STK),
             .RR_LSB(22), .RR_W(4), .RR_ALLOWED(B_ALW)) u_attr_reg (.*);

  function automatic int att(int b);
    return int'(B_ATTR[4*b +: 4]);
  endfunction

  function automatic string req_of(int a);
    case (a)
      0: return "R1";  1: return "R2";  2: return "R3";
      3, 4: return "R4";  5, 6: return "R5";  7, 8: return "R6";
      9: return "R7";  10: return "R8";  default: return "R9";
    endcase
  endfunction

  function automatic bit [NB-1:0] view();
    bit [NB-1:0] v;
    for (int b = 0; b < NB; b++)
      v[b] = (att(b) == 0) ? hw_val_i[b] : (att(b) == 1) ? 1'b0 : m_q[b];
    return v;
  endfunction

  task automatic model_reset();
    m_q = B_RST; m_done = '0; m_evt = '0;
  endtask

  task automatic model_step();
    bit ok, en, d, nq;
    if (!rst_ni) begin model_reset(); return; end
    if (hard_rst_i) begin
      m_evt = '0;
      for (int b = 0; b < NB; b++) if (!B_STK[b]) m_q[b] = B_RST[b];
      return;
    end
    ok = be_i[2] && be_i[3] && B_ALW[wdata_i[25:22]];
    for (int b = 0; b < NB; b++) begin
      en = wr_i && be_i[b/8];
      d  = wdata_i[b];
      nq = m_q[b];
      m_evt[b] = (att(b) == 1) && en && d;
      case (att(b))
        2: if (en) nq = d;
        3: if (rd_i) nq = 0;
        4: begin if (rd_i) nq = 0; if (en) nq = d; end
        5: if (en && d) nq = 0;
        6: if (en && !d) nq = 0;
        7: if (en && d) nq = 1;
        8: if (en && !d) nq = 1;
        9: if (en && !lock_i) nq = d;
        10: if (en && !m_done[b]) begin nq = d; m_done[b] = 1; end
        11: if (en && ok) nq = d;
        default: ;
      endcase
      if (att(b) >= 2) begin
        if (hw_upd_i[b]) nq = hw_val_i[b];
        if (hw_clr_i[b]) nq = 0;
        if (hw_set_i[b]) nq = 1;
      end
      m_q[b] = nq;
    end
  endtask

  task automatic compare();
    bit [NB-1:0] e;
    e = view();
    n_chk++;
    if (rdata_o !== e) begin
      int fb = 0;
      for (int b = NB - 1; b >= 0; b--) if (rdata_o[b] !== e[b]) fb = b;
      n_fail++;
      $display("FAIL %s rdata bit %0d act=%h exp=%h", req_of(att(fb)), fb, rdata_o, e);
    end
    n_chk++;
    if (evt_o !== m_evt) begin
      n_fail++;
      $display("FAIL R2 evt act=%h exp=%h", evt_o, m_evt);
    end
  endtask

  task automatic chk(string name, logic [NB-1:0] act, logic [NB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", name, act, exp);
    end
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic idle();
    wr_i = 0; rd_i = 0; hard_rst_i = 0; be_i = '0; wdata_i = '0;
    hw_set_i = '0; hw_clr_i = '0; hw_upd_i = '0;
  endtask

  task automatic wr(logic [3:0] be, logic [NB-1:0] d);
    idle(); wr_i = 1; be_i = be; wdata_i = d; step();
  endtask

  task automatic por();
    rst_ni = 0; model_reset();
    #1 compare();
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    @(negedge clk_i);
    por();
    chk("R12 defaults after power-on", rdata_o, 32'h1041_0040);
    // R8: write-once field spans bytes 1 and 2 (bits 16:15)
    wr(4'b0010, 32'h0);
    wr(4'b0100, 32'h0);
    wr(4'b1111, 32'hFFFF_FFFF);
    chk("R8 write-once bits keep first value", 32'(rdata_o[16:15]), 32'h0);
    chk("R9 disallowed value 15 ignored", 32'(rdata_o[25:22]), 32'h1);
    wr(4'b1111, 32'h3 << 22);
    chk("R9 allowed value 3 taken", 32'(rdata_o[25:22]), 32'h3);
    wr(4'b0100, 32'h5 << 22);
    chk("R9 partial byte enable ignored", 32'(rdata_o[25:22]), 32'h3);
    // R10: hardware set collides with write-1-to-clear on bit 10
    idle(); wr_i = 1; be_i = 4'hF; wdata_i = 32'h1 << 10; hw_set_i = 32'h1 << 10; step();
    chk("R10 hardware set beats software clear", 32'(rdata_o[10]), 32'h1);
    // R11: sticky bit 18 survives, bit 6 returns to default 1
    wr(4'hF, 32'h1 << 18);
    idle(); hard_rst_i = 1; step();
    chk("R11 sticky bit 18 kept", 32'(rdata_o[18]), 32'h1);
    chk("R11 non-sticky bit 6 default", 32'(rdata_o[6]), 32'h1);
    // R7: locked write
    lock_i = 1;
    wr(4'hF, 32'hFFFF_FFFF);
    lock_i = 0;
    // R4: read-clear after hardware set
    idle(); hw_set_i = 32'h3 << 8; step();
    idle(); rd_i = 1; step();
    idle(); rd_i = 1; wr_i = 1; be_i = 4'h2; wdata_i = 32'h200; step();
    idle(); step();
    for (int i = 0; i < 6000; i++) begin
      idle();
      wr_i = ($urandom_range(0, 1) == 1);
      rd_i = ($urandom_range(0, 1) == 1);
      be_i = 4'($urandom);
      wdata_i = $urandom;
      hw_val_i = $urandom;
      hw_set_i = $urandom & $urandom & $urandom;
      hw_clr_i = $urandom & $urandom & $urandom;
      hw_upd_i = $urandom & $urandom & $urandom;
      if ($urandom_range(0, 15) == 0) lock_i = ~lock_i;
      hard_rst_i = ($urandom_range(0, 63) == 0);
      if (i == 3000) begin
        idle(); hw_val_i = '0;
        por();
        chk("R12 defaults after mid-run power-on", rdata_o, 32'h1041_0040);
      end else begin
        step();
      end
    end
    idle(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule